// File: doc/BRIEF.md
# Iterative Unit Occupancy Tracker

This block keeps the issue stage from sending work to an iterative execution resource that is still occupied by an earlier operation. Three resources are tracked: the integer multiply/divide iterator, the floating-point multiply iterator and the floating-point divide/square-root iterator. Each one has its own down-counter. An accepted issue loads that counter with a fixed worst-case occupancy, chosen by the operation class and its data width. The unit reports busy while its counter is nonzero.

The issue stage presents one operation per cycle: a valid strobe, a 3-bit class code and a width bit. It reads back one busy flag per unit. An operation is accepted only when its target unit is idle. An operation sent to a busy unit is dropped without touching that unit's counter, so the issue stage has to hold it and present it again. The integer unit and the floating-point units never affect one another. All occupancy counts are parameters, and the counter width is derived from the largest of them.

Top module: `iter_occ_tracker`

## Requirements
- R1: A synchronous reset, active low on `rst_n`, clears every counter, and all three busy flags read 0 in the cycle after a reset edge.
- R2: After an accepted issue, the target unit's busy flag rises in the next cycle. It stays high for exactly the occupancy count N of that operation, then drops.
- R3: Integer divide, class code 1, occupies the integer unit for 42 cycles when `issue_wide`=0 (32-bit) and for 72 cycles when `issue_wide`=1 (64-bit).
- R4: Integer multiply or multiply-add, class code 2, occupies the integer unit for 2 cycles when narrow and 7 cycles when wide.
- R5: A move to or from the multiply/divide result registers, class code 3, occupies the integer unit for 3 cycles at either width.
- R6: Floating-point divide or square root, class code 4, occupies the divide/square-root unit for 17 cycles in single precision (`issue_wide`=0) and 32 cycles in double precision.
- R7: Floating-point reciprocal square root, class code 5, occupies the divide/square-root unit for 17 cycles in single precision and 35 cycles in double precision.
- R8: Floating-point multiply or multiply-add, class code 6, occupies the multiply unit for 1 cycle in single precision and 2 cycles in double precision.
- R9: An issue to a unit whose busy flag is high is rejected. It does not reload the counter, so the unit goes idle at the time set by the original issue.
- R10: Each unit's busy flag rises only because of an accepted issue of one of that unit's own classes. The integer unit and the two floating-point units never change one another's occupancy.
- R11: Class codes 0 and 7 target no unit. With `issue_valid` high they leave all busy flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | An operation is presented this cycle |
| issue_op | input | 3 | Class code: 1 int div, 2 int mul, 3 result-register move, 4 fp div/sqrt, 5 fp rsqrt, 6 fp mul, 0/7 none |
| issue_wide | input | 1 | 1 = 64-bit / double precision, 0 = 32-bit / single precision |
| int_busy | output | 1 | Integer multiply/divide iterator occupied |
| fmul_busy | output | 1 | Floating-point multiply iterator occupied |
| fdiv_busy | output | 1 | Floating-point divide/square-root iterator occupied |

## Verification
The bench builds the tracker with its default counts: 42/72, 2/7 and 3 for the integer classes, 17/32, 17/35 and 1/2 for the floating-point classes. The resulting 7-bit counters allow the longest occupancy of 72 cycles to be measured exactly, alongside the shortest one-cycle multiply. The 72-cycle wide divide leaves a long busy window, which gives room to send rejected re-issues and floating-point work into it and to check independence and non-reload. A run of random traffic with roughly one issue in three cycles then overlaps all three units.

// File: rtl/iter_occ_pkg.sv
package iter_occ_pkg;

   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_IDIV = 3'd1,
      OP_IMUL = 3'd2,
      OP_HILO = 3'd3,
      OP_FDIV = 3'd4,
      OP_FRSQ = 3'd5,
      OP_FMUL = 3'd6,
      OP_RSVD = 3'd7
   } iter_op_e;

   localparam int NUM_UNITS = 3;
   localparam int UNIT_INT  = 0;
   localparam int UNIT_FMUL = 1;
   localparam int UNIT_FDIV = 2;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/iter_cost_decode.sv
module iter_cost_decode
   import iter_occ_pkg::*;
#(
   parameter int IDIV_W_CYC = 42,
   parameter int IDIV_D_CYC = 72,
   parameter int IMUL_W_CYC = 2,
   parameter int IMUL_D_CYC = 7,
   parameter int HILO_CYC   = 3,
   parameter int FDIV_S_CYC = 17,
   parameter int FDIV_D_CYC = 32,
   parameter int FRSQ_S_CYC = 17,
   parameter int FRSQ_D_CYC = 35,
   parameter int FMUL_S_CYC = 1,
   parameter int FMUL_D_CYC = 2,
   parameter int CNT_W      = 7
) (
   input  logic                                 valid,
   input  logic [2:0]                           op,
   input  logic                                 wide,
   output logic [NUM_UNITS-1:0]                 hit,
   output logic [NUM_UNITS-1:0][CNT_W-1:0]      len
);

   localparam logic [CNT_W-1:0] L_IDIV_W = CNT_W'(IDIV_W_CYC);
   localparam logic [CNT_W-1:0] L_IDIV_D = CNT_W'(IDIV_D_CYC);
   localparam logic [CNT_W-1:0] L_IMUL_W = CNT_W'(IMUL_W_CYC);
   localparam logic [CNT_W-1:0] L_IMUL_D = CNT_W'(IMUL_D_CYC);
   localparam logic [CNT_W-1:0] L_HILO   = CNT_W'(HILO_CYC);
   localparam logic [CNT_W-1:0] L_FDIV_S = CNT_W'(FDIV_S_CYC);
   localparam logic [CNT_W-1:0] L_FDIV_D = CNT_W'(FDIV_D_CYC);
   localparam logic [CNT_W-1:0] L_FRSQ_S = CNT_W'(FRSQ_S_CYC);
   localparam logic [CNT_W-1:0] L_FRSQ_D = CNT_W'(FRSQ_D_CYC);
   localparam logic [CNT_W-1:0] L_FMUL_S = CNT_W'(FMUL_S_CYC);
   localparam logic [CNT_W-1:0] L_FMUL_D = CNT_W'(FMUL_D_CYC);

   always_comb begin
      hit = '0;
      len = '0;
      case (iter_op_e'(op))
         OP_IDIV: begin
            hit[UNIT_INT] = valid;
            len[UNIT_INT] = wide ? L_IDIV_D : L_IDIV_W;
         end
         OP_IMUL: begin
            hit[UNIT_INT] = valid;
            len[UNIT_INT] = wide ? L_IMUL_D : L_IMUL_W;
         end
         OP_HILO: begin
            hit[UNIT_INT] = valid;
            len[UNIT_INT] = L_HILO;
         end
         OP_FDIV: begin
            hit[UNIT_FDIV] = valid;
            len[UNIT_FDIV] = wide ? L_FDIV_D : L_FDIV_S;
         end
         OP_FRSQ: begin
            hit[UNIT_FDIV] = valid;
            len[UNIT_FDIV] = wide ? L_FRSQ_D : L_FRSQ_S;
         end
         OP_FMUL: begin
            hit[UNIT_FMUL] = valid;
            len[UNIT_FMUL] = wide ? L_FMUL_D : L_FMUL_S;
         end
         default: begin
            hit = '0;
         end
      endcase
   end

endmodule

// File: rtl/iter_occ_counter.sv
module iter_occ_counter #(
   parameter int CNT_W   = 7,
   parameter int MAX_CNT = 72
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic [CNT_W-1:0] len,
   output logic             busy
);

   generate
      if (MAX_CNT == 1) begin : g_flag
         logic flag_q;
         wire  unused_len = ^len;

         always_ff @(posedge clk) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= hit & ~flag_q;
         end
         assign busy = flag_q;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;

         assign busy = |cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)             cnt_q <= '0;
            else if (hit && !busy)  cnt_q <= len;
            else if (busy)          cnt_q <= cnt_q - 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/iter_occ_tracker.sv
module iter_occ_tracker
   import iter_occ_pkg::*;
#(
   parameter int IDIV_W_CYC = 42,
   parameter int IDIV_D_CYC = 72,
   parameter int IMUL_W_CYC = 2,
   parameter int IMUL_D_CYC = 7,
   parameter int HILO_CYC   = 3,
   parameter int FDIV_S_CYC = 17,
   parameter int FDIV_D_CYC = 32,
   parameter int FRSQ_S_CYC = 17,
   parameter int FRSQ_D_CYC = 35,
   parameter int FMUL_S_CYC = 1,
   parameter int FMUL_D_CYC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       issue_valid,
   input  logic [2:0] issue_op,
   input  logic       issue_wide,
   output logic       int_busy,
   output logic       fmul_busy,
   output logic       fdiv_busy
);

   localparam int INT_MAX  = max2(max2(max2(IDIV_W_CYC, IDIV_D_CYC),
                                       max2(IMUL_W_CYC, IMUL_D_CYC)), HILO_CYC);
   localparam int FMUL_MAX = max2(FMUL_S_CYC, FMUL_D_CYC);
   localparam int FDIV_MAX = max2(max2(FDIV_S_CYC, FDIV_D_CYC),
                                  max2(FRSQ_S_CYC, FRSQ_D_CYC));
   localparam int ALL_MAX  = max2(max2(INT_MAX, FMUL_MAX), FDIV_MAX);
   localparam int CNT_W    = (ALL_MAX < 2) ? 1 : $clog2(ALL_MAX + 1);

   generate
      if (IDIV_W_CYC < 1 || IDIV_D_CYC < 1 || IMUL_W_CYC < 1 || IMUL_D_CYC < 1 ||
          HILO_CYC < 1) begin : g_bad_int
         $error("iter_occ_tracker: integer occupancy counts must be at least 1");
      end
      if (FDIV_S_CYC < 1 || FDIV_D_CYC < 1 || FRSQ_S_CYC < 1 || FRSQ_D_CYC < 1 ||
          FMUL_S_CYC < 1 || FMUL_D_CYC < 1) begin : g_bad_fp
         $error("iter_occ_tracker: floating-point occupancy counts must be at least 1");
      end
   endgenerate

   logic [NUM_UNITS-1:0]            hit;
   logic [NUM_UNITS-1:0][CNT_W-1:0] len;
   logic [NUM_UNITS-1:0]            busy_vec;

   iter_cost_decode #(
      .IDIV_W_CYC (IDIV_W_CYC),
      .IDIV_D_CYC (IDIV_D_CYC),
      .IMUL_W_CYC (IMUL_W_CYC),
      .IMUL_D_CYC (IMUL_D_CYC),
      .HILO_CYC   (HILO_CYC),
      .FDIV_S_CYC (FDIV_S_CYC),
      .FDIV_D_CYC (FDIV_D_CYC),
      .FRSQ_S_CYC (FRSQ_S_CYC),
      .FRSQ_D_CYC (FRSQ_D_CYC),
      .FMUL_S_CYC (FMUL_S_CYC),
      .FMUL_D_CYC (FMUL_D_CYC),
      .CNT_W      (CNT_W)
   ) u_decode (
      .valid (issue_valid),
      .op    (issue_op),
      .wide  (issue_wide),
      .hit   (hit),
      .len   (len)
   );

   generate
      for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
         localparam int UNIT_MAX = (u == UNIT_INT)  ? INT_MAX  :
                                   (u == UNIT_FMUL) ? FMUL_MAX : FDIV_MAX;
         iter_occ_counter #(
            .CNT_W   (CNT_W),
            .MAX_CNT (UNIT_MAX)
         ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit[u]),
            .len   (len[u]),
            .busy  (busy_vec[u])
         );
      end
   endgenerate

   assign int_busy  = busy_vec[UNIT_INT];
   assign fmul_busy = busy_vec[UNIT_FMUL];
   assign fdiv_busy = busy_vec[UNIT_FDIV];

endmodule

// File: rtl/iter_occ_tracker_chk.sv
module iter_occ_tracker_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       issue_valid,
   input logic [2:0] issue_op,
   input logic       issue_wide,
   input logic       int_busy,
   input logic       fmul_busy,
   input logic       fdiv_busy
);

   logic op_int, op_fmul, op_fdiv, op_none, all_idle;
   assign op_int   = (issue_op == 3'd1) || (issue_op == 3'd2) || (issue_op == 3'd3);
   assign op_fmul  = (issue_op == 3'd6);
   assign op_fdiv  = (issue_op == 3'd4) || (issue_op == 3'd5);
   assign op_none  = (issue_op == 3'd0) || (issue_op == 3'd7);
   assign all_idle = !int_busy && !fmul_busy && !fdiv_busy;

   wire unused_wide = issue_wide;

   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> all_idle);

   a_r2_int_load: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && op_int && !int_busy) |=> int_busy);

   a_r2_fmul_load: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && op_fmul && !fmul_busy) |=> fmul_busy);

   a_r2_fdiv_load: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && op_fdiv && !fdiv_busy) |=> fdiv_busy);

   a_r10_int_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_busy) |-> $past(issue_valid && op_int));

   a_r10_fmul_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fmul_busy) |-> $past(issue_valid && op_fmul));

   a_r10_fdiv_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fdiv_busy) |-> $past(issue_valid && op_fdiv));

   a_r11_none_op: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && op_none && all_idle) |=> all_idle);

endmodule

bind iter_occ_tracker iter_occ_tracker_chk u_chk (.*);

// File: tb/iter_occ_tracker_tb.sv
module iter_occ_tracker_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       issue_valid = 1'b0;
   logic [2:0] issue_op = 3'd0;
   logic       issue_wide = 1'b0;
   wire        int_busy, fmul_busy, fdiv_busy;

   always #5 clk = ~clk;

   iter_occ_tracker u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_valid (issue_valid),
      .issue_op    (issue_op),
      .issue_wide  (issue_wide),
      .int_busy    (int_busy),
      .fmul_busy   (fmul_busy),
      .fdiv_busy   (fdiv_busy)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";
   int    m_cnt [3];
   int    m_u;

   // Reference: class code to unit (0 int, 1 fmul, 2 fdiv), -1 for none.
   function automatic int ref_unit(input logic [2:0] op);
      case (op)
         3'd1, 3'd2, 3'd3: return 0;
         3'd6:             return 1;
         3'd4, 3'd5:       return 2;
         default:          return -1;
      endcase
   endfunction

   function automatic int ref_len(input logic [2:0] op, input logic w);
      case (op)
         3'd1:    return w ? 72 : 42;
         3'd2:    return w ? 7 : 2;
         3'd3:    return 3;
         3'd4:    return w ? 32 : 17;
         3'd5:    return w ? 35 : 17;
         3'd6:    return w ? 2 : 1;
         default: return 0;
      endcase
   endfunction

   function automatic logic dut_busy(input int u);
      case (u)
         0:       return int_busy;
         1:       return fmul_busy;
         default: return fdiv_busy;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) m_cnt[i] = 0;
      end else begin
         m_u = issue_valid ? ref_unit(issue_op) : -1;
         for (int i = 0; i < 3; i++) begin
            if (i == m_u && m_cnt[i] == 0) m_cnt[i] = ref_len(issue_op, issue_wide);
            else if (m_cnt[i] > 0)         m_cnt[i] = m_cnt[i] - 1;
         end
      end
   end

   task automatic check_bit(input logic act, input logic exp, input string req, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic check_int(input int act, input int exp, input string req, input string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Per-cycle comparison against the reference model.
   always @(negedge clk) begin
      for (int i = 0; i < 3; i++)
         check_bit(dut_busy(i), (m_cnt[i] != 0), cur_req, $sformatf("unit %0d busy per-cycle", i));
   end

   task automatic issue(input logic [2:0] op, input logic w);
      @(negedge clk);
      issue_valid = 1'b1;
      issue_op    = op;
      issue_wide  = w;
      @(negedge clk);
      issue_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (int_busy || fmul_busy || fdiv_busy) @(negedge clk);
   endtask

   task automatic measure(input logic [2:0] op, input logic w, input int u,
                          input int exp, input string req);
      int n;
      cur_req = req;
      wait_idle();
      issue(op, w);
      n = 0;
      while (dut_busy(u) && n < 200) begin
         n++;
         @(negedge clk);
      end
      check_int(n, exp, req, $sformatf("occupancy op=%0d wide=%0b", op, w));
   endtask

   task automatic run_tests();
      int n;
      // R1: reset state
      cur_req = "R1";
      repeat (3) @(negedge clk);
      check_bit(int_busy | fmul_busy | fdiv_busy, 1'b0, "R1", "busy during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_bit(int_busy | fmul_busy | fdiv_busy, 1'b0, "R1", "busy after reset release");

      // R2..R8: occupancy per class and width
      measure(3'd1, 1'b0, 0, 42, "R3");
      measure(3'd1, 1'b1, 0, 72, "R3");
      measure(3'd2, 1'b0, 0, 2,  "R4");
      measure(3'd2, 1'b1, 0, 7,  "R4");
      measure(3'd3, 1'b0, 0, 3,  "R5");
      measure(3'd3, 1'b1, 0, 3,  "R5");
      measure(3'd4, 1'b0, 2, 17, "R6");
      measure(3'd4, 1'b1, 2, 32, "R6");
      measure(3'd5, 1'b0, 2, 17, "R7");
      measure(3'd5, 1'b1, 2, 35, "R7");
      measure(3'd6, 1'b0, 1, 1,  "R8");
      measure(3'd6, 1'b1, 1, 2,  "R2 R8");

      // R9: re-issue into a busy unit must not reload
      cur_req = "R9";
      wait_idle();
      issue(3'd1, 1'b0);
      repeat (8) @(negedge clk);
      issue(3'd1, 1'b1);
      n = 0;
      while (int_busy && n < 200) begin
         n++;
         @(negedge clk);
      end
      check_int(n + 10, 42, "R9", "total occupancy after rejected re-issue");
      wait_idle();
      issue(3'd6, 1'b1);
      issue(3'd6, 1'b1);
      check_bit(fmul_busy, 1'b0, "R9", "fmul after rejected back-to-back issue");

      // R10: independence of integer and floating-point units
      cur_req = "R10";
      wait_idle();
      issue(3'd1, 1'b1);
      issue(3'd4, 1'b1);
      check_bit(int_busy, 1'b1, "R10", "int busy while fdiv issued");
      check_bit(fmul_busy, 1'b0, "R10", "fmul untouched by fdiv issue");
      n = 0;
      while (fdiv_busy && n < 200) begin
         n++;
         @(negedge clk);
      end
      check_int(n, 32, "R10", "fdiv occupancy during int divide");
      check_bit(int_busy, 1'b1, "R10", "int still busy after fdiv done");

      // R11: codes 0 and 7 touch nothing
      cur_req = "R11";
      wait_idle();
      issue(3'd0, 1'b1);
      check_bit(int_busy | fmul_busy | fdiv_busy, 1'b0, "R11", "code 0 sets no busy");
      issue(3'd7, 1'b0);
      check_bit(int_busy | fmul_busy | fdiv_busy, 1'b0, "R11", "code 7 sets no busy");

      // R1: reset in the middle of an occupancy
      cur_req = "R1";
      issue(3'd1, 1'b1);
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_bit(int_busy, 1'b0, "R1", "int busy after mid-run reset");
      rst_n = 1'b1;

      // Random mixed traffic against the model
      cur_req = "R9 R10 random";
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         issue_valid = (($urandom % 3) == 0);
         issue_op    = 3'($urandom % 8);
         issue_wide  = 1'($urandom % 2);
      end
      @(negedge clk);
      issue_valid = 1'b0;
      wait_idle();
      repeat (2) @(negedge clk);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (150000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual=timeout expected=completion");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule